// File: doc/BRIEF.md
# Boot Configuration Word Capture

This block reads a boot configuration word from a set of shared device pads. While power-on reset or hard reset holds the chip, it keeps the pad output drivers off. Board pull-up and pull-down resistors then set the pad levels. The block passes those levels through a synchronizer, and the value present when the reset ends stays in a capture register. After release, the pads carry their functional signals and the register keeps its value until the next power-on or hard reset.

The captured word sits in the upper bits of a 32-bit configuration value. The block decodes it into named settings for clock and boot logic elsewhere in the chip: the core PLL setting, the bus clock divider, the system PLL multiplier, the VCO ratio, the boot vector base, the boot ROM wait-state count and the ROM byte-lane swap. A soft reset has no part in any of this.

Top module: `bootcfg_latch`

## Requirements
- R1: While `por_n` or `hrst_n` is low, every bit of `pad_oe` is 0 and `pad_out` is all zeros, whatever `func_out` carries.
- R2: On the second rising clock edge after both `por_n` and `hrst_n` are high, every bit of `pad_oe` becomes 1 and `pad_out` follows `func_out`. After only one such edge, `pad_oe` is still 0.
- R3: At release, `cfg_word` holds the pad levels seen during reset. Pad i lands in bit 31-i for pads 0 to 12. Bits 18 to 0 are 0.
- R4: Bit 22 of `cfg_word` (pad 9's slot) reads 0 even when pad 9 is held at 1 during reset.
- R5: After release, `cfg_word` and every decoded output stay unchanged while the pads change freely.
- R6: `core_pll_sel` equals `cfg_word[31:27]`, so pad 0 is its most significant bit.
- R7: `bus_div8` equals bit 26 (1 means system clock / 8, 0 means / 4). `sys_mul12` equals bit 25 (1 means ×12, 0 means ×16). `vco_x2` equals bit 24 (1 means the VCO runs at twice the system frequency).
- R8: `boot_vector` is 32'hFFF0_0100 when bit 21 is 1 and 32'h0000_0100 when it is 0.
- R9: `rom_wait` is 48 when bit 20 is 1 and 4 when it is 0. `rom_swap` equals bit 19.
- R10: Pulsing `srst_n` low leaves `pad_oe` high and `cfg_word` unchanged.
- R11: A hard reset on its own, or a power-on reset on its own, captures a new word from the current pad levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, running during reset |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| hrst_n | input | 1 | Hard reset, active low, asynchronous |
| srst_n | input | 1 | Soft reset, active low; has no effect on this block |
| pad_in | input | 13 | Levels read back from the shared pads |
| func_out | input | 13 | Functional values to drive onto the pads after reset |
| pad_out | output | 13 | Values driven to the pad drivers |
| pad_oe | output | 13 | Per-pad output enable, 1 = drive |
| cfg_word | output | 32 | Captured configuration word |
| core_pll_sel | output | 5 | Core PLL setting |
| bus_div8 | output | 1 | Bus clock divider select |
| sys_mul12 | output | 1 | System PLL multiplier select |
| vco_x2 | output | 1 | VCO ratio select |
| boot_vector | output | 32 | Boot vector base address |
| rom_wait | output | 6 | Boot ROM wait-state count in bus clocks |
| rom_swap | output | 1 | Boot ROM byte-lane swap enable |

## Verification
The bench builds the block with its default parameters: 13 pads, two synchronizer stages, the unassigned slot at pad 9, and wait counts of 4 and 48. With two stages, the release latency of exactly two edges can be checked, and both values of every single-bit field are driven across several capture cycles. The unassigned slot is driven high on purpose, to show that it is masked.

// File: rtl/bootcfg_pkg.sv
package bootcfg_pkg;
  localparam int WORD_W   = 32;
  localparam int WORD_TOP = WORD_W - 1;
  // bit positions of the decoded fields in the captured word
  localparam int PLL_HI   = 31;
  localparam int PLL_LO   = 27;
  localparam int PLL_W    = PLL_HI - PLL_LO + 1;
  localparam int BUS_BIT  = 26;
  localparam int MUL_BIT  = 25;
  localparam int VCO_BIT  = 24;
  localparam int VEC_BIT  = 21;
  localparam int WAIT_BIT = 20;
  localparam int SWAP_BIT = 19;
  localparam int WAIT_W   = 6;
endpackage

// File: rtl/bootcfg_rst_sync.sv
module bootcfg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic [STAGES-1:0] sr_q, sr_d;

  always_comb begin
    sr_d = {sr_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sr_q <= '0;
    else         sr_q <= sr_d;
  end

  assign rst_n = sr_q[STAGES-1];
endmodule

// File: rtl/bootcfg_pad_sync.sv
module bootcfg_pad_sync #(
  parameter int W      = 13,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  // runs without reset: it must sample while the chip is held in reset
  logic [W-1:0] st_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) st_q[s] <= din;
    end else begin : g_next
      always_ff @(posedge clk) st_q[s] <= st_q[s-1];
    end
  end

  assign dout = st_q[STAGES-1];
endmodule

// File: rtl/bootcfg_capture.sv
module bootcfg_capture
  import bootcfg_pkg::*;
#(
  parameter int W        = 13,
  parameter int HOLE_PAD = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [W-1:0]      pads_sync,
  output logic [WORD_W-1:0] word
);
  localparam logic [W-1:0] KEEP_MASK = ~(W'(1) << HOLE_PAD);

  logic         load_en;
  logic [W-1:0] cap_q, cap_d;

  // load continuously while reset is held; freeze on release
  assign load_en = !rst_n;

  always_comb begin
    cap_d = cap_q;
    if (load_en) cap_d = pads_sync & KEEP_MASK;
  end

  always_ff @(posedge clk) cap_q <= cap_d;

  for (genvar b = 0; b < WORD_W; b++) begin : g_word
    if (b > WORD_TOP - W) begin : g_pad
      assign word[b] = cap_q[WORD_TOP - b];
    end else begin : g_zero
      assign word[b] = 1'b0;
    end
  end

  // R5
  word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(word));
endmodule

// File: rtl/bootcfg_decode.sv
module bootcfg_decode
  import bootcfg_pkg::*;
#(
  parameter int          WAIT_SHORT = 4,
  parameter int          WAIT_LONG  = 48,
  parameter logic [31:0] VEC_LOW    = 32'h0000_0100,
  parameter logic [31:0] VEC_HIGH   = 32'hFFF0_0100
) (
  input  logic [PLL_W-1:0]  pll_f,
  input  logic              bus_f,
  input  logic              mul_f,
  input  logic              vco_f,
  input  logic              vec_f,
  input  logic              wait_f,
  input  logic              swap_f,
  output logic [PLL_W-1:0]  core_pll_sel,
  output logic              bus_div8,
  output logic              sys_mul12,
  output logic              vco_x2,
  output logic [WORD_W-1:0] boot_vector,
  output logic [WAIT_W-1:0] rom_wait,
  output logic              rom_swap
);
  always_comb begin
    core_pll_sel = pll_f;
    bus_div8     = bus_f;
    sys_mul12    = mul_f;
    vco_x2       = vco_f;
    boot_vector  = vec_f ? VEC_HIGH : VEC_LOW;
    rom_wait     = wait_f ? WAIT_W'(WAIT_LONG) : WAIT_W'(WAIT_SHORT);
    rom_swap     = swap_f;
  end
endmodule

// File: rtl/bootcfg_latch.sv
module bootcfg_latch
  import bootcfg_pkg::*;
#(
  parameter int          PAD_W       = 13,
  parameter int          SYNC_STAGES = 2,
  parameter int          HOLE_PAD    = 9,
  parameter int          WAIT_SHORT  = 4,
  parameter int          WAIT_LONG   = 48,
  parameter logic [31:0] VEC_LOW     = 32'h0000_0100,
  parameter logic [31:0] VEC_HIGH    = 32'hFFF0_0100
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              hrst_n,
  input  logic              srst_n,
  input  logic [PAD_W-1:0]  pad_in,
  input  logic [PAD_W-1:0]  func_out,
  output logic [PAD_W-1:0]  pad_out,
  output logic [PAD_W-1:0]  pad_oe,
  output logic [WORD_W-1:0] cfg_word,
  output logic [PLL_W-1:0]  core_pll_sel,
  output logic              bus_div8,
  output logic              sys_mul12,
  output logic              vco_x2,
  output logic [WORD_W-1:0] boot_vector,
  output logic [WAIT_W-1:0] rom_wait,
  output logic              rom_swap
);
  logic             raw_rst_n;
  logic             rst_n;
  logic [PAD_W-1:0] pads_sync;

  // only the two capture resets combine here; soft reset is not routed in
  assign raw_rst_n = por_n & hrst_n;

  bootcfg_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .arst_n(raw_rst_n), .rst_n(rst_n)
  );

  bootcfg_pad_sync #(.W(PAD_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .din(pad_in), .dout(pads_sync)
  );

  bootcfg_capture #(.W(PAD_W), .HOLE_PAD(HOLE_PAD)) u_cap (
    .clk(clk), .rst_n(rst_n), .pads_sync(pads_sync), .word(cfg_word)
  );

  bootcfg_decode #(
    .WAIT_SHORT(WAIT_SHORT), .WAIT_LONG(WAIT_LONG),
    .VEC_LOW(VEC_LOW), .VEC_HIGH(VEC_HIGH)
  ) u_dec (
    .pll_f(cfg_word[PLL_HI:PLL_LO]), .bus_f(cfg_word[BUS_BIT]),
    .mul_f(cfg_word[MUL_BIT]), .vco_f(cfg_word[VCO_BIT]),
    .vec_f(cfg_word[VEC_BIT]), .wait_f(cfg_word[WAIT_BIT]),
    .swap_f(cfg_word[SWAP_BIT]),
    .core_pll_sel(core_pll_sel), .bus_div8(bus_div8), .sys_mul12(sys_mul12),
    .vco_x2(vco_x2), .boot_vector(boot_vector), .rom_wait(rom_wait),
    .rom_swap(rom_swap)
  );

  // per-pad tristate control
  for (genvar p = 0; p < PAD_W; p++) begin : g_pad
    assign pad_oe[p]  = rst_n;
    assign pad_out[p] = rst_n & func_out[p];
  end

  // R1
  oe_off_in_reset_chk: assert property (@(posedge clk) disable iff (srst_n === 1'bx)
    !raw_rst_n |-> (pad_oe == '0));

  // R9
  wait_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rom_wait == WAIT_W'(WAIT_SHORT)) || (rom_wait == WAIT_W'(WAIT_LONG)));

  // R8
  vector_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (boot_vector == VEC_LOW) || (boot_vector == VEC_HIGH));

  // R10
  soft_rst_inert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!srst_n && $past(rst_n)) |-> (&pad_oe && $stable(cfg_word)));
endmodule

// File: tb/bootcfg_latch_tb.sv
module bootcfg_latch_tb;
  localparam int CLK_PERIOD = 10;
  localparam int PW = 13;

  logic          clk = 1'b0;
  logic          por_n, hrst_n, srst_n;
  logic [PW-1:0] pad_in, func_out;
  logic [PW-1:0] pad_out, pad_oe;
  logic [31:0]   cfg_word, boot_vector;
  logic [4:0]    core_pll_sel;
  logic          bus_div8, sys_mul12, vco_x2, rom_swap;
  logic [5:0]    rom_wait;

  int checks = 0;
  int fails  = 0;
  logic [31:0] exp_q[$];
  logic [31:0] last_exp;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bootcfg_latch u_dut (
    .clk(clk), .por_n(por_n), .hrst_n(hrst_n), .srst_n(srst_n),
    .pad_in(pad_in), .func_out(func_out), .pad_out(pad_out), .pad_oe(pad_oe),
    .cfg_word(cfg_word), .core_pll_sel(core_pll_sel), .bus_div8(bus_div8),
    .sys_mul12(sys_mul12), .vco_x2(vco_x2), .boot_vector(boot_vector),
    .rom_wait(rom_wait), .rom_swap(rom_swap)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] model(logic [PW-1:0] p);
    logic [31:0] w = '0;
    for (int i = 0; i < PW; i++) if (i != 9) w[31-i] = p[i];
    return w;
  endfunction

  // driver: reset with chosen source, push expected word
  task automatic do_reset(bit use_por, logic [PW-1:0] pads);
    @(negedge clk);
    pad_in = pads;
    if (use_por) por_n = 1'b0; else hrst_n = 1'b0;
    repeat (4) @(negedge clk);
    check("R1 oe", {19'b0, pad_oe}, 32'h0);
    check("R1 out", {19'b0, pad_out}, 32'h0);
    exp_q.push_back(model(pads));
    last_exp = model(pads);
    if (use_por) por_n = 1'b1; else hrst_n = 1'b1;
    @(negedge clk);
    check("R2 one edge", {19'b0, pad_oe}, 32'h0);
    @(negedge clk);
    check("R2 oe", {19'b0, pad_oe}, {19'b0, {PW{1'b1}}});
    check("R2 out", {19'b0, pad_out}, {19'b0, func_out});
    repeat (3) @(negedge clk);
  endtask

  // monitor: on each release, pop and compare the captured result
  initial begin
    forever begin
      @(posedge pad_oe[0]);
      @(negedge clk);
      if (exp_q.size() == 0) begin
        check("R3 unexpected", 32'h1, 32'h0);
      end else begin
        automatic logic [31:0] e = exp_q.pop_front();
        check("R3 word", cfg_word, e);
        check("R4 hole", {31'b0, cfg_word[22]}, 32'h0);
        check("R6 pll", {27'b0, core_pll_sel}, {27'b0, e[31:27]});
        check("R7 bus/mul/vco", {29'b0, bus_div8, sys_mul12, vco_x2}, {29'b0, e[26:24]});
        check("R8 vector", boot_vector, e[21] ? 32'hFFF0_0100 : 32'h0000_0100);
        check("R9 wait", {26'b0, rom_wait}, e[20] ? 32'd48 : 32'd4);
        check("R9 swap", {31'b0, rom_swap}, {31'b0, e[19]});
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 5000);
    fails++;
    $display("FAIL watchdog expired actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    por_n = 1'b1; hrst_n = 1'b1; srst_n = 1'b1;
    pad_in = '0; func_out = 13'h15A5;
    #1 por_n = 1'b0;
    do_reset(1'b1, 13'h1FFF);            // R4: pad 9 high, masked
    do_reset(1'b0, 13'h0000);            // R11 hard reset alone
    do_reset(1'b1, 13'b1_0101_0100_0001); // R11 power-on alone
    do_reset(1'b0, 13'b0_1010_1011_1110);
    // R5: pads change after release
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      pad_in = ~pad_in ^ 13'(k);
      repeat (3) @(negedge clk);
      check("R5 hold", cfg_word, last_exp);
    end
    check("R5 vector", boot_vector, last_exp[21] ? 32'hFFF0_0100 : 32'h0000_0100);
    // R10: soft reset pulse
    @(negedge clk);
    pad_in = 13'h0F0F;
    srst_n = 1'b0;
    repeat (4) @(negedge clk);
    check("R10 oe", {19'b0, pad_oe}, {19'b0, {PW{1'b1}}});
    check("R10 word", cfg_word, last_exp);
    srst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R10 word after", cfg_word, last_exp);
    check("R3 queue drained", exp_q.size(), 32'h0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule